// File: doc/BRIEF.md
# Lockable Multi-Channel Watchdog Timer

This block is a countdown watchdog controlled through a small word-addressed register port. Software first loads a reload count, a mask of service channels and a configuration word, then writes a start command. From that point the counter steps down once per slow tick pulse. Before the count runs out, software must write a fixed key to every enabled service channel. If it does not, the block raises a one-cycle watchdog reset request.

Starting the watchdog is a one-way step. Once it is running, writes to the three setup registers are discarded, and no register write can halt the counter. A soft reset request from the rest of the chip leaves the watchdog running. Only the power-on, external pin and brownout reset inputs clear the block, together with its own timeout. A sticky timeout flag outlives every reset source except power-on, so that boot code can tell why the chip restarted.

Register map (word addresses): 0 start task, 1 reload count, 2 channel enable mask, 3 configuration, 4 status (bit 0 running, bit 1 timeout seen), 5 channels awaiting service, 6 live counter value, 8+i service channel i.

Top module: `wdl_top`

## Requirements
- R1: While any hard reset input is low, and once it returns high, status, counter, reload count, mask, configuration and pending all read 0 and `wdt_rst_o` is 0.
- R2: A write at address 0 with data bit 0 set, while stopped, sets running (status bit 0, read at address 4) and loads the counter (read at address 6) with the reload count. Each tick pulse while running lowers the counter by one.
- R3: A tick that finds the counter at 1 or 0 while running sets the counter to 0 and drives `wdt_rst_o` high for exactly one cycle, starting at the clock edge that takes the tick. At the next edge, running, counter, reload, mask and configuration clear, and status bit 1 (timeout seen) sets.
- R4: While running, writes to addresses 1, 2 and 3 are ignored, and reading them back returns the values held at start.
- R5: While running, writing 0 to the start task or clearing the mask does not stop the counter. A second start command does not reload the counter.
- R6: Asserting `soft_rst_i` changes neither the running state nor the counter.
- R7: `por_n`, `pin_rst_n` or `bor_n` low clears running, counter and setup registers. Status bit 1 is cleared only by `por_n`.
- R8: A write to address 8+i counts as a service of channel i only when the data equals 32'h6E524635, channel i's mask bit is set and the watchdog is running. Any other such write is ignored.
- R9: When a valid service write completes the set of enabled channels serviced since the last reload, the counter reloads and the serviced flags clear. A reload takes priority over a tick in the same cycle. A mask of zero never reloads.
- R10: Address 5 reads the enabled channels not yet serviced (mask AND NOT serviced) while running, and 0 while stopped.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| pin_rst_n | input | 1 | External pin reset, active low |
| bor_n | input | 1 | Brownout reset, active low |
| soft_rst_i | input | 1 | Chip soft reset request, ignored by the watchdog |
| tick_i | input | 1 | Slow count tick, one clock wide |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| wdt_rst_o | output | 1 | Watchdog reset request, one cycle |

## Verification
A lock that leaks shows up at once as a changed readback of the reload count, mask or configuration after a write while running. A wrong serviced flag shows up in the pending field on the very next read, and as a missed or early reload of the counter. An error in the count or in the timeout comparison is visible on the tick that should fire. There, `wdt_rst_o` is either missing or too wide, and the status and counter reads one cycle later show whether the self-clear and the sticky flag behaved. Reset qualification faults appear as a running bit that survives a hard reset pulse, or as a sticky flag lost on a pin or brownout reset.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
   localparam int unsigned WDL_DW = 32;
   localparam logic [WDL_DW-1:0] WDL_KEY = 32'h6E52_4635;
   localparam logic [7:0] A_START  = 8'd0;
   localparam logic [7:0] A_RELOAD = 8'd1;
   localparam logic [7:0] A_MASK   = 8'd2;
   localparam logic [7:0] A_CFG    = 8'd3;
   localparam logic [7:0] A_STAT   = 8'd4;
   localparam logic [7:0] A_PEND   = 8'd5;
   localparam logic [7:0] A_COUNT  = 8'd6;
   localparam logic [7:0] A_CHBASE = 8'd8;
endpackage

// File: rtl/wdl_regs.sv
module wdl_regs #(
   parameter int unsigned CNT_W = 24,
   parameter int unsigned NCH   = 4,
   parameter int unsigned CFG_W = 8
) (
   input  logic             clk,
   input  logic             hard_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             wr_reload_i,
   input  logic             wr_mask_i,
   input  logic             wr_cfg_i,
   input  logic [31:0]      wdata_i,
   output logic [CNT_W-1:0] reload_q,
   output logic [NCH-1:0]   mask_q,
   output logic [CFG_W-1:0] cfg_q
);
   logic open_w;
   assign open_w = !run_i;

   always_ff @(posedge clk or negedge hard_n) begin
      if (!hard_n) begin
         reload_q <= '0;
         mask_q   <= '0;
         cfg_q    <= '0;
      end else if (clr_i) begin
         reload_q <= '0;
         mask_q   <= '0;
         cfg_q    <= '0;
      end else if (open_w) begin
         if (wr_reload_i) reload_q <= wdata_i[CNT_W-1:0];
         if (wr_mask_i)   mask_q   <= wdata_i[NCH-1:0];
         if (wr_cfg_i)    cfg_q    <= wdata_i[CFG_W-1:0];
      end
   end

   // R4
   setup_locked_chk: assert property (@(posedge clk) disable iff (!hard_n)
      (run_i && !clr_i) |=> ($stable(reload_q) && $stable(mask_q) && $stable(cfg_q)));
endmodule

// File: rtl/wdl_svc.sv
module wdl_svc #(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           hard_n,
   input  logic           clr_i,
   input  logic           run_i,
   input  logic           key_ok_i,
   input  logic [NCH-1:0] chan_wr_i,
   input  logic [NCH-1:0] mask_i,
   output logic [NCH-1:0] pend_o,
   output logic           reload_o
);
   logic [NCH-1:0] flags_q;
   logic [NCH-1:0] valid_w;
   logic [NCH-1:0] flags_nxt;
   logic           all_done;

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         assign valid_w[gi] = chan_wr_i[gi] && key_ok_i && mask_i[gi] && run_i;
         always_ff @(posedge clk or negedge hard_n) begin
            if (!hard_n)                        flags_q[gi] <= 1'b0;
            else if (clr_i || !run_i || reload_o) flags_q[gi] <= 1'b0;
            else                                flags_q[gi] <= flags_nxt[gi];
         end
      end
   endgenerate

   assign flags_nxt = flags_q | valid_w;
   assign all_done  = (mask_i != '0) && ((flags_nxt & mask_i) == mask_i);
   assign reload_o  = run_i && (valid_w != '0) && all_done;
   assign pend_o    = run_i ? (mask_i & ~flags_q) : '0;

   // R8
   flag_in_mask_chk: assert property (@(posedge clk) disable iff (!hard_n)
      (flags_q & ~mask_i) == '0);
   // R9
   zero_mask_chk: assert property (@(posedge clk) disable iff (!hard_n)
      (mask_i == '0) |-> !reload_o);
endmodule

// File: rtl/wdl_count.sv
module wdl_count #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             hard_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] reload_val_i,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             fire_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge hard_n) begin
      if (!hard_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (fire_q) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (!run_q) begin
            if (start_i) begin
               run_q <= 1'b1;
               cnt_q <= reload_val_i;
            end
         end else if (reload_i) begin
            cnt_q <= reload_val_i;
         end else if (tick_i) begin
            if (cnt_q <= ONE) begin
               cnt_q  <= '0;
               fire_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   // R3
   one_cycle_rst_chk: assert property (@(posedge clk) disable iff (!hard_n)
      fire_q |=> !fire_q);
   // R5
   no_sw_stop_chk: assert property (@(posedge clk) disable iff (!hard_n)
      $fell(run_q) |-> $past(fire_q));
   // R2
   count_down_chk: assert property (@(posedge clk) disable iff (!hard_n)
      (run_q && !reload_i && !fire_q) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/wdl_top.sv
module wdl_top #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned NCH    = 4,
   parameter int unsigned CFG_W  = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DW     = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pin_rst_n,
   input  logic              bor_n,
   input  logic              soft_rst_i,
   input  logic              tick_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              wdt_rst_o
);
   import wdl_pkg::*;

   generate
      if (DW != WDL_DW)               $error("wdl_top: DW must be 32");
      if (NCH < 1 || NCH > 8)         $error("wdl_top: NCH out of range");
      if (CNT_W < 2 || CNT_W > 32)    $error("wdl_top: CNT_W out of range");
      if (CFG_W < 1 || CFG_W > 32)    $error("wdl_top: CFG_W out of range");
      if (ADDR_W < 4 || ADDR_W > 8)   $error("wdl_top: ADDR_W out of range");
   endgenerate

   logic             hard_n;
   logic             run_w;
   logic             fire_w;
   logic             reload_w;
   logic             start_w;
   logic             key_ok_w;
   logic             chan_sel_w;
   logic             timeout_q;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] reload_q;
   logic [NCH-1:0]   mask_q;
   logic [NCH-1:0]   pend_w;
   logic [NCH-1:0]   chan_wr_w;
   logic [CFG_W-1:0] cfg_q;

   assign hard_n     = por_n & pin_rst_n & bor_n;
   assign start_w    = wr_i && (addr_i == ADDR_W'(A_START)) && wdata_i[0];
   assign key_ok_w   = (wdata_i == WDL_KEY);
   assign chan_sel_w = (addr_i >> 3) == ADDR_W'(A_CHBASE >> 3);

   genvar gc;
   generate
      for (gc = 0; gc < NCH; gc++) begin : g_dec
         assign chan_wr_w[gc] = wr_i && chan_sel_w && (addr_i[2:0] == 3'(gc));
      end
   endgenerate

   wdl_regs #(.CNT_W(CNT_W), .NCH(NCH), .CFG_W(CFG_W)) u_regs (
      .clk         (clk),
      .hard_n      (hard_n),
      .clr_i       (fire_w),
      .run_i       (run_w),
      .wr_reload_i (wr_i && (addr_i == ADDR_W'(A_RELOAD))),
      .wr_mask_i   (wr_i && (addr_i == ADDR_W'(A_MASK))),
      .wr_cfg_i    (wr_i && (addr_i == ADDR_W'(A_CFG))),
      .wdata_i     (wdata_i),
      .reload_q    (reload_q),
      .mask_q      (mask_q),
      .cfg_q       (cfg_q)
   );

   wdl_svc #(.NCH(NCH)) u_svc (
      .clk       (clk),
      .hard_n    (hard_n),
      .clr_i     (fire_w),
      .run_i     (run_w),
      .key_ok_i  (key_ok_w),
      .chan_wr_i (chan_wr_w),
      .mask_i    (mask_q),
      .pend_o    (pend_w),
      .reload_o  (reload_w)
   );

   wdl_count #(.CNT_W(CNT_W)) u_count (
      .clk          (clk),
      .hard_n       (hard_n),
      .start_i      (start_w),
      .tick_i       (tick_i),
      .reload_i     (reload_w),
      .reload_val_i (reload_q),
      .cnt_q        (cnt_w),
      .run_q        (run_w),
      .fire_q       (fire_w)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      timeout_q <= 1'b0;
      else if (fire_w) timeout_q <= 1'b1;
   end

   assign wdt_rst_o = fire_w;

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(A_RELOAD))     rdata_o = 32'(reload_q);
      else if (addr_i == ADDR_W'(A_MASK))  rdata_o = 32'(mask_q);
      else if (addr_i == ADDR_W'(A_CFG))   rdata_o = 32'(cfg_q);
      else if (addr_i == ADDR_W'(A_STAT))  rdata_o = {30'd0, timeout_q, run_w};
      else if (addr_i == ADDR_W'(A_PEND))  rdata_o = 32'(pend_w);
      else if (addr_i == ADDR_W'(A_COUNT)) rdata_o = 32'(cnt_w);
   end

   // R6
   soft_ignored_chk: assert property (@(posedge clk) disable iff (!hard_n)
      (soft_rst_i && run_w && !fire_w) |=> run_w);
   // R7
   sticky_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
      timeout_q |=> timeout_q);
endmodule

// File: tb/wdl_top_bench.sv
`timescale 1ns/1ps
module wdl_top_bench;
   localparam logic [31:0] KEY = 32'h6E52_4635;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, pin_rst_n = 1'b1, bor_n = 1'b1;
   logic        soft_rst_i = 1'b0, tick_i = 1'b0, wr_i = 1'b0;
   logic [4:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        wdt_rst_o;
   int          total = 0;
   int          bad = 0;

   always #2 clk = ~clk;

   wdl_top u_wdl_top (
      .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .bor_n(bor_n),
      .soft_rst_i(soft_rst_i), .tick_i(tick_i), .wr_i(wr_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .wdt_rst_o(wdt_rst_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      addr_i = a;
      #1 d = rdata_o;
   endtask

   task automatic tick(output logic seen);
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      seen = wdt_rst_o;
   endtask

   task automatic pulse_rst(input int which);
      @(negedge clk);
      if (which == 0) por_n = 1'b0;
      else if (which == 1) pin_rst_n = 1'b0;
      else bor_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1; pin_rst_n = 1'b1; bor_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(5'd4, d); chk("R1 status", d, 0);
      rd(5'd6, d); chk("R1 count", d, 0);
      rd(5'd1, d); chk("R1 reload", d, 0);
      rd(5'd5, d); chk("R1 pending", d, 0);
      chk("R1 wdt_rst", {31'd0, wdt_rst_o}, 0);
   endtask

   task automatic t_start();
      logic [31:0] d; logic s;
      wr(5'd1, 32'd5); wr(5'd2, 32'd3); wr(5'd3, 32'hA5);
      wr(5'd0, 32'd1);
      rd(5'd4, d); chk("R2 running", d, 1);
      rd(5'd6, d); chk("R2 loaded", d, 5);
      tick(s); tick(s);
      rd(5'd6, d); chk("R2 count after 2 ticks", d, 3);
      rd(5'd5, d); chk("R10 pending all", d, 3);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      wr(5'd1, 32'd100); wr(5'd2, 32'd0); wr(5'd3, 32'd0);
      rd(5'd1, d); chk("R4 reload locked", d, 5);
      rd(5'd2, d); chk("R4 mask locked", d, 3);
      rd(5'd3, d); chk("R4 cfg locked", d, 32'hA5);
      wr(5'd0, 32'd0);
      rd(5'd4, d); chk("R5 start zero no stop", d, 1);
      wr(5'd0, 32'd1);
      rd(5'd6, d); chk("R5 restart no reload", d, 3);
   endtask

   task automatic t_key();
      logic [31:0] d; logic s;
      wr(5'd8, KEY ^ 32'h1);
      rd(5'd5, d); chk("R8 bad key ignored", d, 3);
      wr(5'd10, KEY);
      rd(5'd5, d); chk("R8 disabled channel ignored", d, 3);
      rd(5'd6, d); chk("R8 no reload", d, 3);
      wr(5'd8, KEY);
      rd(5'd5, d); chk("R10 pending after ch0", d, 2);
      tick(s);
      rd(5'd6, d); chk("R9 partial no reload", d, 2);
      wr(5'd9, KEY);
      rd(5'd6, d); chk("R9 reload", d, 5);
      rd(5'd5, d); chk("R9 flags cleared", d, 3);
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr(5'd8, KEY);
      @(negedge clk);
      wr_i = 1'b1; addr_i = 5'd9; wdata_i = KEY; tick_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0; tick_i = 1'b0;
      rd(5'd6, d); chk("R9 reload beats tick", d, 5);
   endtask

   task automatic t_soft();
      logic [31:0] d;
      @(negedge clk); soft_rst_i = 1'b1;
      repeat (3) @(negedge clk);
      soft_rst_i = 1'b0;
      rd(5'd4, d); chk("R6 still running", d, 1);
      rd(5'd6, d); chk("R6 count kept", d, 5);
   endtask

   task automatic t_timeout();
      logic [31:0] d; logic s;
      for (int i = 0; i < 4; i++) begin
         tick(s); chk("R3 no early fire", {31'd0, s}, 0);
      end
      rd(5'd6, d); chk("R3 count at one", d, 1);
      tick(s); chk("R3 fire", {31'd0, s}, 1);
      @(negedge clk); chk("R3 one cycle", {31'd0, wdt_rst_o}, 0);
      rd(5'd4, d); chk("R3 stopped and sticky", d, 2);
      rd(5'd1, d); chk("R3 reload cleared", d, 0);
      rd(5'd5, d); chk("R10 pending when stopped", d, 0);
   endtask

   task automatic t_hard();
      logic [31:0] d;
      wr(5'd1, 32'd7); wr(5'd2, 32'd1); wr(5'd0, 32'd1);
      rd(5'd4, d); chk("R7 restarted", d, 3);
      pulse_rst(1);
      rd(5'd4, d); chk("R7 pin clears run keeps sticky", d, 2);
      rd(5'd6, d); chk("R7 pin clears count", d, 0);
      rd(5'd2, d); chk("R7 pin clears mask", d, 0);
      wr(5'd1, 32'd9); wr(5'd0, 32'd1);
      pulse_rst(2);
      rd(5'd4, d); chk("R7 brownout clears run", d, 2);
      pulse_rst(0);
      rd(5'd4, d); chk("R7 por clears sticky", d, 0);
   endtask

   task automatic t_zero_mask();
      logic [31:0] d; logic s;
      wr(5'd1, 32'd3); wr(5'd2, 32'd0); wr(5'd0, 32'd1);
      wr(5'd8, KEY);
      tick(s); tick(s);
      rd(5'd6, d); chk("R9 zero mask no reload", d, 1);
      tick(s); chk("R9 zero mask expires", {31'd0, s}, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      por_n = 1'b1;
      t_reset();
      t_start();
      t_lock();
      t_key();
      t_prio();
      t_soft();
      t_timeout();
      t_hard();
      t_zero_mask();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule